// File: doc/BRIEF.md
# Dual-Port Memory with Cross-Port Mailbox Interrupts

This block is a synchronous, two-port 4096 x 18 memory with two identical ports, left and right. Either port can read or write any word in any cycle. Each port also has an active-low interrupt output that the opposite port raises through a mailbox word.

The two highest addresses are mailboxes. When the left side writes the top word, the right interrupt goes low. The right side clears it by reading that word. The word just below the top works the same way in the other direction: a right write raises the left interrupt and a left read clears it. The mailbox words are ordinary storage, so the sender can leave a message value that the receiver reads back in the same access that acknowledges it.

Each port has an active-low busy input that an outside arbiter drives. While a port's busy input is low, its accesses still reach the memory but cannot change any interrupt flag.

Top module: `dpram_mbox`

## Requirements
- R1: A port writes when `ce_ni` = 0 and `wr_ni` = 0. It reads when `ce_ni` = 0, `oe_ni` = 0 and `wr_ni` = 1. Read data is registered: it appears on `rdata_o` after the next rising clock edge and holds its value in every cycle without a read.
- R2: If one port reads an address in the same cycle that the other port writes it, the read returns the value the word held before that write.
- R3: If both ports write the same address in the same cycle, the left port's data is stored.
- R4: A left write to address 0xFFF with `l_busy_ni` = 1 drives `r_int_no` low after that clock edge.
- R5: A right read of address 0xFFF with `r_busy_ni` = 1 drives `r_int_no` high after that clock edge.
- R6: A right write to 0xFFE with `r_busy_ni` = 1 drives `l_int_no` low. A left read of 0xFFE with `l_busy_ni` = 1 drives it high again.
- R7: If the busy input of the accessing port is low, that access does not change any interrupt flag. The memory is still accessed.
- R8: The two mailbox words store and return data like any other word.
- R9: While `rst_ni` = 0, both interrupt outputs are high and both `rdata_o` outputs are zero.
- R10: A flag changes only through the accesses in R4 to R6. If a set and a clear of the same flag happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_ce_ni | input | 1 | Left chip enable, active low |
| l_wr_ni | input | 1 | Left write select, 0 = write, 1 = read |
| l_oe_ni | input | 1 | Left output enable, active low |
| l_busy_ni | input | 1 | Left busy; when low, left accesses change no flag |
| l_addr_i | input | 12 | Left word address |
| l_wdata_i | input | 18 | Left write data |
| l_rdata_o | output | 18 | Left registered read data |
| l_int_no | output | 1 | Left interrupt, active low |
| r_ce_ni | input | 1 | Right chip enable, active low |
| r_wr_ni | input | 1 | Right write select, 0 = write, 1 = read |
| r_oe_ni | input | 1 | Right output enable, active low |
| r_busy_ni | input | 1 | Right busy; when low, right accesses change no flag |
| r_addr_i | input | 12 | Right word address |
| r_wdata_i | input | 18 | Right write data |
| r_rdata_o | output | 18 | Right registered read data |
| r_int_no | output | 1 | Right interrupt, active low |

## Verification
The assertions check the following on every cycle:
- A qualified mailbox write drops the interrupt one edge later.
- A qualified read with no competing set raises the interrupt again.
- A flag with neither event stays where it is.
- Read data holds between reads, and both interrupts stay high during reset.

Only the bench scenarios can show the data-path outcomes:
- The collision outcomes in R2 and R3.
- That the message value written to a mailbox comes back on the receiving side.
- That busy suppresses a flag change while the word is still written.

// File: rtl/dpram_mbox_pkg.sv
package dpram_mbox_pkg;
  typedef enum int unsigned {
    PORT_L = 0,
    PORT_R = 1
  } port_e;

  localparam int unsigned NUM_PORTS = 2;

  function automatic logic is_wr(input logic ce_n, input logic wr_n);
    return !ce_n && !wr_n;
  endfunction

  function automatic logic is_rd(input logic ce_n, input logic oe_n, input logic wr_n);
    return !ce_n && !oe_n && wr_n;
  endfunction
endpackage

// File: rtl/dpram_store.sv
module dpram_store
  import dpram_mbox_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni    [NUM_PORTS],
  input  logic          wr_ni    [NUM_PORTS],
  input  logic          oe_ni    [NUM_PORTS],
  input  logic [AW-1:0] addr_i   [NUM_PORTS],
  input  logic [DW-1:0] wdata_i  [NUM_PORTS],
  output logic [DW-1:0] rdata_o  [NUM_PORTS]
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic          wr_en [NUM_PORTS];
  logic          rd_en [NUM_PORTS];
  logic          same_addr;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
    assign wr_en[p] = is_wr(ce_ni[p], wr_ni[p]);
    assign rd_en[p] = is_rd(ce_ni[p], oe_ni[p], wr_ni[p]);
  end

  assign same_addr = (addr_i[PORT_L] == addr_i[PORT_R]);

  // left has priority on a same-address write collision
  always_ff @(posedge clk_i) begin
    if (wr_en[PORT_R] && !(wr_en[PORT_L] && same_addr))
      mem_q[addr_i[PORT_R]] <= wdata_i[PORT_R];
    if (wr_en[PORT_L])
      mem_q[addr_i[PORT_L]] <= wdata_i[PORT_L];
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       rdata_o[p] <= '0;
      else if (rd_en[p]) rdata_o[p] <= mem_q[addr_i[p]];
    end

    // R1
    rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_en[p] |=> $stable(rdata_o[p]));
  end
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag
  import dpram_mbox_pkg::*;
#(
  parameter int unsigned    AW      = 12,
  parameter logic [AW-1:0]  MB_ADDR = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          snd_ce_ni,
  input  logic          snd_wr_ni,
  input  logic          snd_busy_ni,
  input  logic [AW-1:0] snd_addr_i,
  input  logic          rcv_ce_ni,
  input  logic          rcv_wr_ni,
  input  logic          rcv_oe_ni,
  input  logic          rcv_busy_ni,
  input  logic [AW-1:0] rcv_addr_i,
  output logic          int_no
);
  logic set_ev, clr_ev;

  assign set_ev = is_wr(snd_ce_ni, snd_wr_ni) && (snd_addr_i == MB_ADDR) && snd_busy_ni;
  assign clr_ev = is_rd(rcv_ce_ni, rcv_oe_ni, rcv_wr_ni) && (rcv_addr_i == MB_ADDR) && rcv_busy_ni;

  // set beats clear so a fresh message is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     int_no <= 1'b1;
    else if (set_ev) int_no <= 1'b0;
    else if (clr_ev) int_no <= 1'b1;
  end

  // R4
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!snd_ce_ni && !snd_wr_ni && snd_busy_ni && snd_addr_i == MB_ADDR) |=> !int_no);

  // R5
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rcv_ce_ni && !rcv_oe_ni && rcv_wr_ni && rcv_busy_ni && rcv_addr_i == MB_ADDR
     && !(snd_ce_ni == 1'b0 && snd_wr_ni == 1'b0 && snd_busy_ni && snd_addr_i == MB_ADDR))
    |=> int_no);

  // R7
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_ev && !clr_ev) |=> $stable(int_no));
endmodule

// File: rtl/dpram_mbox.sv
module dpram_mbox
  import dpram_mbox_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          l_ce_ni,
  input  logic          l_wr_ni,
  input  logic          l_oe_ni,
  input  logic          l_busy_ni,
  input  logic [AW-1:0] l_addr_i,
  input  logic [DW-1:0] l_wdata_i,
  output logic [DW-1:0] l_rdata_o,
  output logic          l_int_no,
  input  logic          r_ce_ni,
  input  logic          r_wr_ni,
  input  logic          r_oe_ni,
  input  logic          r_busy_ni,
  input  logic [AW-1:0] r_addr_i,
  input  logic [DW-1:0] r_wdata_i,
  output logic [DW-1:0] r_rdata_o,
  output logic          r_int_no
);
  localparam logic [AW-1:0] MB_TO_R = '1;
  localparam logic [AW-1:0] MB_TO_L = MB_TO_R - 1'b1;

  logic          ce_n   [NUM_PORTS];
  logic          wr_n   [NUM_PORTS];
  logic          oe_n   [NUM_PORTS];
  logic          busy_n [NUM_PORTS];
  logic [AW-1:0] addr   [NUM_PORTS];
  logic [DW-1:0] wdata  [NUM_PORTS];
  logic [DW-1:0] rdata  [NUM_PORTS];
  logic [NUM_PORTS-1:0] int_n;

  assign ce_n[PORT_L]   = l_ce_ni;   assign ce_n[PORT_R]   = r_ce_ni;
  assign wr_n[PORT_L]   = l_wr_ni;   assign wr_n[PORT_R]   = r_wr_ni;
  assign oe_n[PORT_L]   = l_oe_ni;   assign oe_n[PORT_R]   = r_oe_ni;
  assign busy_n[PORT_L] = l_busy_ni; assign busy_n[PORT_R] = r_busy_ni;
  assign addr[PORT_L]   = l_addr_i;  assign addr[PORT_R]   = r_addr_i;
  assign wdata[PORT_L]  = l_wdata_i; assign wdata[PORT_R]  = r_wdata_i;

  assign l_rdata_o = rdata[PORT_L];
  assign r_rdata_o = rdata[PORT_R];
  assign l_int_no  = int_n[PORT_L];
  assign r_int_no  = int_n[PORT_R];

  dpram_store #(.AW(AW), .DW(DW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ce_ni   (ce_n),
    .wr_ni   (wr_n),
    .oe_ni   (oe_n),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  // one flag per direction: port s sends, port 1-s receives
  for (genvar s = 0; s < NUM_PORTS; s++) begin : g_mbox
    localparam int unsigned RCV = NUM_PORTS - 1 - s;
    localparam logic [AW-1:0] MB = (s == PORT_L) ? MB_TO_R : MB_TO_L;

    mbox_flag #(.AW(AW), .MB_ADDR(MB)) u_flag (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .snd_ce_ni   (ce_n[s]),
      .snd_wr_ni   (wr_n[s]),
      .snd_busy_ni (busy_n[s]),
      .snd_addr_i  (addr[s]),
      .rcv_ce_ni   (ce_n[RCV]),
      .rcv_wr_ni   (wr_n[RCV]),
      .rcv_oe_ni   (oe_n[RCV]),
      .rcv_busy_ni (busy_n[RCV]),
      .rcv_addr_i  (addr[RCV]),
      .int_no      (int_n[RCV])
    );
  end

  // R9
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      rst_int_chk: assert (l_int_no && r_int_no);
    end
  end
endmodule

// File: tb/dpram_mbox_tb_top.sv
module dpram_mbox_tb_top;
  localparam int AW = 12;
  localparam int DW = 18;

  typedef struct {
    int          due;
    int          sel;   // 0/1 rdata of port, 2/3 int of port
    logic [DW-1:0] exp;
    string       req;
  } item_t;

  logic clk = 0, rst_ni = 1;
  logic          ce_n [2], wr_n [2], oe_n [2], busy_n [2];
  logic [AW-1:0] addr [2];
  logic [DW-1:0] wdata [2];
  logic [DW-1:0] l_rdata, r_rdata;
  logic          l_int_n, r_int_n;

  item_t         sb_q [$];
  logic [DW-1:0] mdl [int];
  logic          int_m [2];
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dpram_mbox #(.AW(AW), .DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .l_ce_ni(ce_n[0]), .l_wr_ni(wr_n[0]), .l_oe_ni(oe_n[0]), .l_busy_ni(busy_n[0]),
    .l_addr_i(addr[0]), .l_wdata_i(wdata[0]), .l_rdata_o(l_rdata), .l_int_no(l_int_n),
    .r_ce_ni(ce_n[1]), .r_wr_ni(wr_n[1]), .r_oe_ni(oe_n[1]), .r_busy_ni(busy_n[1]),
    .r_addr_i(addr[1]), .r_wdata_i(wdata[1]), .r_rdata_o(r_rdata), .r_int_no(r_int_n)
  );

  // monitor
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      item_t it;
      logic [DW-1:0] act;
      it = sb_q.pop_front();
      case (it.sel)
        0: act = l_rdata;
        1: act = r_rdata;
        2: act = {{(DW-1){1'b0}}, l_int_n};
        default: act = {{(DW-1){1'b0}}, r_int_n};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s sel=%0d actual=%h expected=%h cyc=%0d", it.req, it.sel, act, it.exp, cyc);
      end
    end
  end

  task automatic idle();
    for (int p = 0; p < 2; p++) begin
      ce_n[p] = 1; wr_n[p] = 1; oe_n[p] = 1; addr[p] = '0; wdata[p] = '0;
    end
  endtask

  task automatic wr(int p, logic [AW-1:0] a, logic [DW-1:0] d);
    ce_n[p] = 0; wr_n[p] = 0; oe_n[p] = 1; addr[p] = a; wdata[p] = d;
  endtask

  task automatic rd(int p, logic [AW-1:0] a);
    ce_n[p] = 0; wr_n[p] = 1; oe_n[p] = 0; addr[p] = a;
  endtask

  task automatic push(int sel, logic [DW-1:0] e, string req, int due);
    item_t it;
    it.due = due; it.sel = sel; it.exp = e; it.req = req;
    sb_q.push_back(it);
  endtask

  // driver: compute expectations from current inputs, then clock once
  task automatic tick(string req);
    logic is_w [2], is_r [2];
    for (int p = 0; p < 2; p++) begin
      is_w[p] = !ce_n[p] && !wr_n[p];
      is_r[p] = !ce_n[p] && !oe_n[p] && wr_n[p];
      if (is_r[p]) push(p, mdl.exists(int'(addr[p])) ? mdl[int'(addr[p])] : 'x, req, cyc + 1);
    end
    for (int s = 0; s < 2; s++) begin
      int r = 1 - s;
      logic [AW-1:0] mb = (s == 0) ? 12'hFFF : 12'hFFE;
      if (is_w[s] && addr[s] == mb && busy_n[s]) int_m[r] = 0;
      else if (is_r[r] && addr[r] == mb && busy_n[r]) int_m[r] = 1;
    end
    push(2, {{(DW-1){1'b0}}, int_m[0]}, req, cyc + 1);
    push(3, {{(DW-1){1'b0}}, int_m[1]}, req, cyc + 1);
    if (is_w[1]) mdl[int'(addr[1])] = wdata[1];
    if (is_w[0]) mdl[int'(addr[0])] = wdata[0];
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    busy_n[0] = 1; busy_n[1] = 1;
    int_m[0] = 1; int_m[1] = 1;
    #1 rst_ni = 0;
    @(negedge clk);
    // R9 reset state
    push(0, '0, "R9", cyc + 1); push(1, '0, "R9", cyc + 1);
    push(2, 18'h1, "R9", cyc + 1); push(3, 18'h1, "R9", cyc + 1);
    @(posedge clk); @(negedge clk);
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 plain write/read on both ports
    wr(0, 12'h00A, 18'h12345); tick("R1");
    rd(0, 12'h00A); tick("R1");
    wr(1, 12'h014, 18'h2ABCD); tick("R1");
    rd(0, 12'h014); rd(1, 12'h00A); tick("R1");
    tick("R1");  // no read: rdata holds (checked through flag stream + next read)
    rd(1, 12'h014); tick("R1");

    // R2 read-during-write returns old data
    wr(0, 12'h01E, 18'h0AAAA); tick("R2");
    wr(1, 12'h01E, 18'h15555); rd(0, 12'h01E); tick("R2");
    rd(0, 12'h01E); tick("R2");

    // R3 write collision, left wins
    wr(0, 12'h028, 18'h0C0C0); wr(1, 12'h028, 18'h30303); tick("R3");
    rd(1, 12'h028); tick("R3");

    // R4 / R8 left sends to right
    wr(0, 12'hFFF, 18'h3F00F); tick("R4");
    tick("R10");
    rd(0, 12'hFFF); tick("R10");           // sender's read does not clear
    ce_n[1] = 0; wr_n[1] = 1; oe_n[1] = 1; addr[1] = 12'hFFF; tick("R10"); // oe high, no clear
    rd(1, 12'hFFF); tick("R5");            // returns message, clears
    rd(1, 12'hFFF); tick("R8");

    // R6 right sends to left
    wr(1, 12'hFFE, 18'h00777); tick("R6");
    rd(1, 12'hFFE); tick("R10");
    rd(0, 12'hFFE); tick("R6");

    // R7 busy suppresses flag changes, memory still written
    busy_n[0] = 0; wr(0, 12'hFFF, 18'h11111); tick("R7");
    busy_n[0] = 1; rd(1, 12'hFFF); tick("R7");
    wr(0, 12'hFFF, 18'h22222); tick("R4");
    busy_n[1] = 0; rd(1, 12'hFFF); tick("R7");
    busy_n[1] = 1; rd(1, 12'hFFF); tick("R5");
    busy_n[1] = 0; wr(1, 12'hFFE, 18'h00999); tick("R7");

    // R10 set and clear together: set wins
    busy_n[1] = 1; wr(1, 12'hFFE, 18'h00123); tick("R6");
    wr(1, 12'hFFE, 18'h00456); rd(0, 12'hFFE); tick("R10");
    rd(0, 12'hFFE); tick("R8");
    wr(0, 12'hFFF, 18'h00001); rd(1, 12'hFFF); tick("R10");
    rd(1, 12'hFFF); tick("R5");

    tick("R1");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule